// File: doc/BRIEF.md
# UART Receive Byte Queue with Trigger and Timeout

This block sits between a UART deserialiser and the register interface. Every received character enters with its byte and three error marks: parity, framing and break. The block holds up to 64 such characters and hands them out oldest first. It raises a data-available request once the fill level reaches a threshold that software selects. It also raises a timeout flag when characters have waited unread for several character times. An error summary tells software that at least one character still held is marked bad.

Both data paths use valid/ready handshakes. On the input side, `in_ready` is high exactly when there is room. The deserialiser cannot be stalled, so it still presents `in_valid` when `in_ready` is low. That byte is then discarded and `overrun` pulses. On the output side, `out_valid` is the data-ready indication and a read happens on any cycle with `out_valid && out_ready`. Neither ready depends combinationally on its own valid.

Clearing `fifo_en` turns the queue into a single holding byte. Any change of `fifo_en` empties the store. A synchronous `flush` also empties it, and the transmit side is not involved.

Top module: `uart_rx_fifo`

## Requirements
- R1: Accepted characters leave in arrival order. `out_data` and the three output error marks always show the oldest stored character. Each character keeps its own marks.
- R2: After reset the store is empty: `level`=0, `out_valid`=0, `in_ready`=1. A write happens on `in_valid && in_ready` and a read on `out_valid && out_ready`. `level` gives the stored count, and `out_valid` is high exactly when `level` is not 0.
- R3: With `fifo_en`=1, `in_ready` falls once 64 characters are held. A character presented while `in_ready` is low is dropped and the stored contents are unchanged. `overrun` is then high for the one cycle that follows.
- R4: With `fifo_en`=1, `trig_req` is high exactly when `level` is at or above the threshold chosen by `trig_sel`: 2'b00 gives 1, 2'b01 gives 8, 2'b10 gives 16 and 2'b11 gives 32.
- R5: With `fifo_en`=0 the capacity is one character, and `trig_req` is high whenever that character is present, whatever `trig_sel` holds. `mode_stat` reads 2'b11 when `fifo_en`=1 and 2'b00 when `fifo_en`=0.
- R6: Any change of `fifo_en` leaves the store empty after the next clock edge.
- R7: When `flush` is high at a clock edge, the store is empty after that edge. A write or read presented in the same cycle has no effect.
- R8: With `fifo_en`=1 and the store not empty, `tmo_flag` rises after the fourth `char_tick` cycle that passes with no accepted write or read. It stays high until a write, read, flush or mode change clears it, and any write or read restarts the count. With `fifo_en`=0 or an empty store, `tmo_flag` stays 0.
- R9: `err_any` is high exactly when at least one stored character carries a parity, framing or break mark.
- R10: A write and a read accepted in the same cycle leave `level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: 64-entry queue, 0: single holding byte |
| flush | input | 1 | Synchronous empty command |
| trig_sel | input | 2 | Trigger threshold code |
| char_tick | input | 1 | One-cycle pulse per character time |
| in_valid | input | 1 | Deserialiser presents a character |
| in_ready | output | 1 | Room for a character |
| in_data | input | 8 | Received byte |
| in_perr | input | 1 | Parity error mark |
| in_ferr | input | 1 | Framing error mark |
| in_brk | input | 1 | Break mark |
| out_valid | output | 1 | Data ready: at least one character held |
| out_ready | input | 1 | Register interface reads the head |
| out_data | output | 8 | Oldest byte |
| out_perr | output | 1 | Parity mark of oldest byte |
| out_ferr | output | 1 | Framing mark of oldest byte |
| out_brk | output | 1 | Break mark of oldest byte |
| level | output | 7 | Stored character count |
| trig_req | output | 1 | Data-available request |
| tmo_flag | output | 1 | Character timeout detected |
| mode_stat | output | 2 | Enable status, 2'b11 or 2'b00 |
| err_any | output | 1 | Some stored character carries an error mark |
| overrun | output | 1 | One-cycle pulse after a dropped character |

## Verification
The assertions assume that `rst_n` is held low across at least one clock edge and that `char_tick` is a single-cycle pulse. They also assume that `fifo_en` and `flush` change only between edges, and that the error-mark inputs are valid whenever `in_valid` is high. The stimulus drives every input only at falling edges. It also pulses `char_tick` for exactly one cycle per character time, and it changes `fifo_en` only on its own cycle, with no other traffic. Overrun is forced only with `in_valid` held while `in_ready` is low.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  localparam int unsigned RXQ_BYTE_W = 8;
  localparam int unsigned RXQ_MARK_W = 3;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rxq_marks_t;

  function automatic int unsigned rxq_threshold(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 8;
      2'b10:   return 16;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 11,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          cap_one,
  input  logic          wr_req,
  input  logic [W-1:0]  wr_word,
  input  logic          rd_req,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic          full,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  assign full    = cap_one ? (count != '0) : (count == CW'(DEPTH));
  assign wr_fire = wr_req && !full && !clear;
  assign rd_fire = rd_req && (count != '0) && !clear;
  assign head    = mem[rd_ptr];

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_fire) wr_ptr <= wr_nxt;
      if (rd_fire) rd_ptr <= rd_nxt;
      case ({wr_fire, rd_fire})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full && !rd_req && !clear) |=> $stable(count));

  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));

  p_rw_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && rd_req && !full && count != '0 && !clear) |=> $stable(count));

endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int unsigned TMO_CHARS = 4,
  localparam int unsigned TW       = $clog2(TMO_CHARS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  input  logic tick,
  output logic flag
);

  logic [TW-1:0] ticks;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !active) begin
      ticks <= '0;
      flag  <= 1'b0;
    end else if (tick && !flag) begin
      if (ticks == TW'(TMO_CHARS - 1)) begin
        flag  <= 1'b1;
        ticks <= '0;
      end else begin
        ticks <= ticks + TW'(1);
      end
    end
  end

  p_tmo_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !flag);

  p_tmo_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !flag);

  p_tmo_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !tick) |=> !flag);

endmodule

// File: rtl/rxq_errtrack.sv
module rxq_errtrack #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_fire,
  input  logic          wr_bad,
  input  logic          rd_fire,
  input  logic          rd_bad,
  output logic [CW-1:0] bad_cnt,
  output logic          err_any
);

  logic inc, dec;

  assign inc     = wr_fire && wr_bad;
  assign dec     = rd_fire && rd_bad;
  assign err_any = (bad_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      bad_cnt <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   bad_cnt <= bad_cnt + CW'(1);
        2'b01:   bad_cnt <= bad_cnt - CW'(1);
        default: bad_cnt <= bad_cnt;
      endcase
    end
  end

  p_err_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (bad_cnt != '0));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned DATA_W    = RXQ_BYTE_W,
  parameter int unsigned TMO_CHARS = 4,
  localparam int unsigned LVL_W    = $clog2(DEPTH + 1),
  localparam int unsigned SW       = DATA_W + RXQ_MARK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              flush,
  input  logic [1:0]        trig_sel,
  input  logic              char_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_perr,
  input  logic              in_ferr,
  input  logic              in_brk,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_perr,
  output logic              out_ferr,
  output logic              out_brk,
  output logic [LVL_W-1:0]  level,
  output logic              trig_req,
  output logic              tmo_flag,
  output logic [1:0]        mode_stat,
  output logic              err_any,
  output logic              overrun
);

  logic             en_q;
  logic             mode_chg, clr;
  logic             wr_fire, rd_fire, full;
  logic [SW-1:0]    in_word, head;
  rxq_marks_t       in_marks, head_marks;
  logic [LVL_W-1:0] bad_cnt;
  int unsigned      thr;

  assign mode_chg = (fifo_en != en_q);
  assign clr      = flush || mode_chg;

  assign in_marks = '{brk: in_brk, ferr: in_ferr, perr: in_perr};
  assign in_word  = {in_marks, in_data};

  rxq_store #(.DEPTH(DEPTH), .W(SW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clr),
    .cap_one (!fifo_en),
    .wr_req  (in_valid),
    .wr_word (in_word),
    .rd_req  (out_ready),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire),
    .full    (full),
    .head    (head),
    .count   (level)
  );

  assign head_marks = rxq_marks_t'(head[SW-1:DATA_W]);
  assign out_data   = head[DATA_W-1:0];
  assign out_perr   = head_marks.perr;
  assign out_ferr   = head_marks.ferr;
  assign out_brk    = head_marks.brk;
  assign out_valid  = (level != '0);
  assign in_ready   = !full;

  assign thr      = fifo_en ? rxq_threshold(trig_sel) : 1;
  assign trig_req = (32'(level) >= thr);
  assign mode_stat = {2{fifo_en}};

  rxq_timeout #(.TMO_CHARS(TMO_CHARS)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (fifo_en && out_valid),
    .restart (wr_fire || rd_fire || clr),
    .tick    (char_tick),
    .flag    (tmo_flag)
  );

  rxq_errtrack #(.DEPTH(DEPTH)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clr),
    .wr_fire (wr_fire),
    .wr_bad  (|in_marks),
    .rd_fire (rd_fire),
    .rd_bad  (|head_marks),
    .bad_cnt (bad_cnt),
    .err_any (err_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b1;
      overrun <= 1'b0;
    end else begin
      en_q    <= fifo_en;
      overrun <= in_valid && full;
    end
  end

  p_tmo_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag |-> (level != '0));

  p_err_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cnt <= level);

  p_bypass_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !en_q) |-> (level <= LVL_W'(1)));

  p_mode_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (level == '0));

  p_ovr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overrun);

endmodule

// File: tb/tb_uart_rx_fifo.sv
`timescale 1ns/1ps
module tb_uart_rx_fifo;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, fifo_en, flush, char_tick;
  logic [1:0] trig_sel;
  logic       in_valid, in_ready, in_perr, in_ferr, in_brk;
  logic [7:0] in_data, out_data;
  logic       out_valid, out_ready, out_perr, out_ferr, out_brk;
  logic [6:0] level;
  logic       trig_req, tmo_flag, err_any, overrun;
  logic [1:0] mode_stat;

  uart_rx_fifo dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush),
    .trig_sel(trig_sel), .char_tick(char_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_perr(in_perr), .in_ferr(in_ferr), .in_brk(in_brk),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_perr(out_perr), .out_ferr(out_ferr), .out_brk(out_brk),
    .level(level), .trig_req(trig_req), .tmo_flag(tmo_flag),
    .mode_stat(mode_stat), .err_any(err_any), .overrun(overrun)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  // word layout: {brk, ferr, perr, data[7:0]}
  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [10:0] wd;
    logic [10:0] er;
    logic [6:0]  lvl;
    logic        trig;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 11'h011, 11'h000, 7'd1, 1'b0},
    '{1'b1, 1'b0, 11'h022, 11'h000, 7'd2, 1'b0},
    '{1'b1, 1'b0, 11'h133, 11'h000, 7'd3, 1'b0},
    '{1'b1, 1'b0, 11'h044, 11'h000, 7'd4, 1'b0},
    '{1'b1, 1'b0, 11'h055, 11'h000, 7'd5, 1'b0},
    '{1'b1, 1'b0, 11'h066, 11'h000, 7'd6, 1'b0},
    '{1'b1, 1'b0, 11'h077, 11'h000, 7'd7, 1'b0},
    '{1'b1, 1'b0, 11'h088, 11'h000, 7'd8, 1'b1},
    '{1'b0, 1'b1, 11'h000, 11'h011, 7'd7, 1'b0},
    '{1'b0, 1'b1, 11'h000, 11'h022, 7'd6, 1'b0},
    '{1'b1, 1'b1, 11'h499, 11'h133, 7'd6, 1'b0},
    '{1'b0, 1'b1, 11'h000, 11'h044, 7'd5, 1'b0},
    '{1'b0, 1'b1, 11'h000, 11'h055, 7'd4, 1'b0},
    '{1'b0, 1'b1, 11'h000, 11'h066, 7'd3, 1'b0},
    '{1'b0, 1'b1, 11'h000, 11'h077, 7'd2, 1'b0},
    '{1'b0, 1'b1, 11'h000, 11'h088, 7'd1, 1'b0},
    '{1'b0, 1'b1, 11'h000, 11'h499, 7'd0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] m);
    in_valid = 1'b1;
    in_data  = d;
    {in_brk, in_ferr, in_perr} = m;
    cyc();
    in_valid = 1'b0;
    {in_brk, in_ferr, in_perr} = 3'b000;
  endtask

  task automatic pop();
    out_ready = 1'b1;
    cyc();
    out_ready = 1'b0;
  endtask

  task automatic tick();
    char_tick = 1'b1;
    cyc();
    char_tick = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    cyc();
    flush = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fifo_en = 1'b1; flush = 1'b0; char_tick = 1'b0;
    trig_sel = 2'b01; in_valid = 1'b0; in_data = '0;
    in_perr = 1'b0; in_ferr = 1'b0; in_brk = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();

    // R2 reset state
    chk("R2 reset level", 32'(level), 0);
    chk("R2 reset out_valid", 32'(out_valid), 0);
    chk("R2 reset in_ready", 32'(in_ready), 1);
    chk("R4 reset trig_req", 32'(trig_req), 0);
    chk("R8 reset tmo_flag", 32'(tmo_flag), 0);
    chk("R9 reset err_any", 32'(err_any), 0);
    chk("R5 reset mode_stat", 32'(mode_stat), 3);
    chk("R3 reset overrun", 32'(overrun), 0);

    // table walk, trigger code 2'b01 (threshold 8)
    for (int i = 0; i < NV; i++) begin
      in_valid  = VEC[i].wr;
      {in_brk, in_ferr, in_perr, in_data} = VEC[i].wd;
      out_ready = VEC[i].rd;
      #1;
      if (VEC[i].rd)
        chk("R1 head word", 32'({out_brk, out_ferr, out_perr, out_data}), 32'(VEC[i].er));
      cyc();
      in_valid = 1'b0; out_ready = 1'b0;
      {in_brk, in_ferr, in_perr} = 3'b000;
      if (VEC[i].wr && VEC[i].rd)
        chk("R10 level on read+write", 32'(level), 32'(VEC[i].lvl));
      else
        chk("R2 level", 32'(level), 32'(VEC[i].lvl));
      chk("R4 trig_req sel=01", 32'(trig_req), 32'(VEC[i].trig));
    end

    // R3 fill to 64, overrun, then drain in order (R1)
    trig_sel = 2'b00;
    for (int i = 0; i < 64; i++) push(8'(i), 3'b000);
    chk("R3 full level", 32'(level), 64);
    chk("R3 full in_ready", 32'(in_ready), 0);
    push(8'hEE, 3'b000);
    chk("R3 overrun pulse", 32'(overrun), 1);
    chk("R3 level kept", 32'(level), 64);
    cyc();
    chk("R3 overrun one cycle", 32'(overrun), 0);
    for (int i = 0; i < 64; i++) begin
      chk("R1 order after overrun", 32'(out_data), 32'(i));
      pop();
    end
    chk("R2 drained out_valid", 32'(out_valid), 0);

    // R4 thresholds 32, 16, 1
    for (int i = 0; i < 31; i++) push(8'h00, 3'b000);
    trig_sel = 2'b11; #1;
    chk("R4 sel=11 at 31", 32'(trig_req), 0);
    push(8'h00, 3'b000);
    chk("R4 sel=11 at 32", 32'(trig_req), 1);
    trig_sel = 2'b10; #1;
    chk("R4 sel=10 at 32", 32'(trig_req), 1);
    do_flush();
    chk("R7 flush level", 32'(level), 0);
    chk("R7 flush out_valid", 32'(out_valid), 0);
    for (int i = 0; i < 15; i++) push(8'h00, 3'b000);
    chk("R4 sel=10 at 15", 32'(trig_req), 0);
    push(8'h00, 3'b000);
    chk("R4 sel=10 at 16", 32'(trig_req), 1);
    do_flush();
    trig_sel = 2'b00; #1;
    chk("R4 sel=00 at 0", 32'(trig_req), 0);
    push(8'h00, 3'b000);
    chk("R4 sel=00 at 1", 32'(trig_req), 1);

    // R7 flush beats a concurrent write and read
    flush = 1'b1; in_valid = 1'b1; in_data = 8'h77; out_ready = 1'b1;
    cyc();
    flush = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    chk("R7 flush with write", 32'(level), 0);

    // R8 timeout
    push(8'h5A, 3'b000);
    repeat (3) tick();
    chk("R8 no timeout after 3", 32'(tmo_flag), 0);
    tick();
    chk("R8 timeout after 4", 32'(tmo_flag), 1);
    tick();
    chk("R8 timeout stays", 32'(tmo_flag), 1);
    pop();
    chk("R8 read clears", 32'(tmo_flag), 0);
    push(8'h01, 3'b000);
    repeat (3) tick();
    push(8'h02, 3'b000);
    chk("R8 write clears", 32'(tmo_flag), 0);
    repeat (3) tick();
    chk("R8 restarted count", 32'(tmo_flag), 0);
    tick();
    chk("R8 timeout after restart", 32'(tmo_flag), 1);
    do_flush();
    chk("R8 flush clears", 32'(tmo_flag), 0);
    repeat (5) tick();
    chk("R8 empty no timeout", 32'(tmo_flag), 0);

    // R9 error summary
    push(8'h10, 3'b010);
    push(8'h20, 3'b000);
    chk("R9 marked entry held", 32'(err_any), 1);
    chk("R1 framing mark at head", 32'(out_ferr), 1);
    pop();
    chk("R9 marked entry gone", 32'(err_any), 0);
    pop();
    push(8'h30, 3'b000);
    push(8'h40, 3'b100);
    pop();
    chk("R9 marked entry behind", 32'(err_any), 1);
    pop();
    chk("R9 all read", 32'(err_any), 0);

    // R5 / R6 bypass mode
    push(8'h01, 3'b000);
    push(8'h02, 3'b000);
    push(8'h03, 3'b000);
    trig_sel = 2'b11;
    fifo_en = 1'b0;
    cyc();
    chk("R6 disable empties", 32'(level), 0);
    chk("R5 mode_stat off", 32'(mode_stat), 0);
    push(8'hA1, 3'b000);
    chk("R5 holding level", 32'(level), 1);
    chk("R5 holding full", 32'(in_ready), 0);
    chk("R5 holding trig_req", 32'(trig_req), 1);
    push(8'hA2, 3'b000);
    chk("R3 bypass overrun", 32'(overrun), 1);
    chk("R5 holding byte kept", 32'(out_data), 32'h00A1);
    repeat (5) tick();
    chk("R8 no timeout in bypass", 32'(tmo_flag), 0);
    fifo_en = 1'b1;
    cyc();
    chk("R6 enable empties", 32'(level), 0);
    chk("R5 mode_stat on", 32'(mode_stat), 3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule